// File: doc/BRIEF.md
# Sorted-Edge Delta Bit Packer

This block compresses a bucket of edge values that arrive already sorted in ascending order. For each accepted value it forms the gap to the previously accepted value of the same bucket, and it codes the first value of a bucket against zero. Each gap becomes a variable-length code: a unary count of the gap's significant bits, then those bits themselves. The codes are laid end to end into a continuous bit stream, which leaves the block as fixed-width words. Because the stream is written and read strictly in order, only the gaps need storing. With 1024 buckets, the top ten bits of an endpoint select the bucket, so the gaps span only the remaining low bits and average well under 15 coded bits each.

Values enter on a valid/ready port with a marker on the last value of the bucket. Packed words leave on a second valid/ready port. When the last value has been coded, the partly filled word is padded with zeros and sent with a final flag. The previous-value register then returns to zero for the next bucket. An input that is smaller than its predecessor sets a sticky error flag.

Top module: `edge_delta_packer`

## Requirements
- R1: The coded gap is the accepted value minus the previous accepted value of the same bucket, taken modulo 2^VAL_W. The first value of a bucket is coded against zero.
- R2: For a gap whose bit length is L (0 for a zero gap), the code is L one-bits, then a zero-bit, then the L low bits of the gap, least significant first. Its total length is 2L+1 bits.
- R3: Code bits fill each output word from bit 0 upward with no gaps, and a code may be split across two consecutive words.
- R4: Words leave in stream order. While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o and out_last_o hold their values.
- R5: After the last value of a bucket, the final partial word is sent with zeros above the last code bit and with out_last_o high. out_last_o is low on every other word.
- R6: After a value marked last is accepted, the next accepted value is coded against zero.
- R7: in_ready_o is low while at least OUT_W coded bits wait in the buffer, or while the final word of a bucket is still pending.
- R8: Accepting a value smaller than the previous one sets err_o, which stays high until reset. The value is still coded, with the wrapped gap.
- R9: After reset, out_valid_o and err_o are low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input value valid |
| in_ready_o | output | 1 | Block can take a value |
| in_value_i | input | VAL_W | Sorted edge value (low bits within bucket) |
| in_last_i | input | 1 | Value is the last of its bucket |
| out_valid_o | output | 1 | Packed word valid |
| out_ready_i | input | 1 | Consumer takes the word |
| out_data_o | output | OUT_W | Packed code bits, LSB first |
| out_last_o | output | 1 | Final word of the bucket |
| err_o | output | 1 | Sticky ordering error |

## Verification
When a value is accepted at a clock edge, its code bits land in the buffer at that same edge. If the buffer then holds a full word, or the bucket is closed, out_valid_o and the word can be seen in the following cycle. err_o likewise rises one cycle after the offending value is accepted. The bench drives inputs and samples outputs a fixed delay after the falling edge. It evaluates each handshake on values that have settled before the next rising edge, and it compares every word as it is taken against a queue of words built arithmetically from the gaps. Random stalls on both ports exercise the hold rule and the input throttle.

// File: rtl/edp_pkg.sv
package edp_pkg;
  // worst-case code: VAL_W unary ones, a stop bit, VAL_W payload bits
  function automatic int code_width(int val_w);
    return 2 * val_w + 1;
  endfunction
endpackage

// File: rtl/edp_delta.sv
module edp_delta #(
  parameter int VAL_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VAL_W-1:0] value_i,
  input  logic             accept_i,
  input  logic             last_i,
  output logic [VAL_W-1:0] gap_o,
  output logic             err_o
);
  logic [VAL_W-1:0] prev_q;
  logic             err_q;

  assign gap_o = value_i - prev_q;
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      err_q  <= 1'b0;
    end else if (accept_i) begin
      prev_q <= last_i ? '0 : value_i;
      if (value_i < prev_q) err_q <= 1'b1;
    end
  end

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_err_on_descent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && (value_i < prev_q)) |=> err_q);
  p_bucket_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && last_i) |=> (prev_q == '0));
endmodule

// File: rtl/edp_coder.sv
module edp_coder #(
  parameter int VAL_W  = 22,
  parameter int CODE_W = 45,
  parameter int TLEN_W = 6
) (
  input  logic [VAL_W-1:0]  gap_i,
  output logic [CODE_W-1:0] code_o,
  output logic [TLEN_W-1:0] len_o
);
  localparam int LEN_W = $clog2(VAL_W + 1);

  logic [LEN_W-1:0]  sig_len;
  logic [CODE_W-1:0] ones;
  logic [CODE_W-1:0] payload;

  always_comb begin
    sig_len = '0;
    for (int i = 0; i < VAL_W; i++)
      if (gap_i[i]) sig_len = LEN_W'(i + 1);
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < VAL_W; i++)
      ones[i] = (i < int'(sig_len));
  end

  assign payload = {{(CODE_W-VAL_W){1'b0}}, gap_i} << (int'(sig_len) + 1);
  assign code_o  = ones | payload;
  assign len_o   = TLEN_W'(2 * int'(sig_len) + 1);
endmodule

// File: rtl/edp_packer.sv
module edp_packer #(
  parameter int OUT_W  = 32,
  parameter int CODE_W = 45,
  parameter int TLEN_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic [TLEN_W-1:0] len_i,
  input  logic              push_i,
  input  logic              last_i,
  output logic              room_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              out_last_o
);
  localparam int ACC_W = OUT_W + CODE_W;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] OUT_CNT = CNT_W'(OUT_W);
  localparam logic [CNT_W-1:0] ACC_CNT = CNT_W'(ACC_W);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flush_q;
  logic             pop;

  assign room_o      = (cnt_q < OUT_CNT) && !flush_q;
  assign out_valid_o = (cnt_q >= OUT_CNT) || (flush_q && (cnt_q != '0));
  assign out_last_o  = flush_q && (cnt_q <= OUT_CNT);
  assign out_data_o  = acc_q[OUT_W-1:0];
  assign pop         = out_valid_o && out_ready_i;

  // push and pop never coincide: room needs fewer than a word and no flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (pop) begin
      acc_q <= acc_q >> OUT_W;
      if (cnt_q <= OUT_CNT) begin
        cnt_q   <= '0;
        flush_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - OUT_CNT;
      end
    end else if (push_i) begin
      acc_q   <= acc_q | ({{OUT_W{1'b0}}, code_i} << cnt_q);
      cnt_q   <= cnt_q + CNT_W'(len_i);
      flush_q <= last_i;
    end
  end

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ACC_CNT);
  p_push_has_room_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < OUT_CNT) && !flush_q);
  p_final_drains_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && out_last_o) |=> (cnt_q == '0) && !out_valid_o);
endmodule

// File: rtl/edge_delta_packer.sv
module edge_delta_packer #(
  parameter int VAL_W = 22,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [VAL_W-1:0] in_value_i,
  input  logic             in_last_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o,
  output logic             out_last_o,
  output logic             err_o
);
  localparam int CODE_W = edp_pkg::code_width(VAL_W);
  localparam int TLEN_W = $clog2(CODE_W + 1);

  logic              accept;
  logic [VAL_W-1:0]  gap;
  logic [CODE_W-1:0] code;
  logic [TLEN_W-1:0] code_len;

  assign accept = in_valid_i && in_ready_o;

  edp_delta #(.VAL_W(VAL_W)) u_delta (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .value_i  (in_value_i),
    .accept_i (accept),
    .last_i   (in_last_i),
    .gap_o    (gap),
    .err_o    (err_o)
  );

  edp_coder #(.VAL_W(VAL_W), .CODE_W(CODE_W), .TLEN_W(TLEN_W)) u_coder (
    .gap_i  (gap),
    .code_o (code),
    .len_o  (code_len)
  );

  edp_packer #(.OUT_W(OUT_W), .CODE_W(CODE_W), .TLEN_W(TLEN_W)) u_packer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .code_i      (code),
    .len_i       (code_len),
    .push_i      (accept),
    .last_i      (in_last_i),
    .room_o      (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o)
  );
endmodule

// File: tb/edge_delta_packer_bench.sv
module edge_delta_packer_bench;
  localparam int VW = 8;
  localparam int OW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_value = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_data;
  logic          out_last;
  logic          err;

  int n_tests = 0;
  int n_fail  = 0;

  logic [VW-1:0] in_vals[$];
  logic          in_lasts[$];
  logic [OW-1:0] exp_words[$];
  logic          exp_lasts[$];

  always #5 clk = ~clk;

  edge_delta_packer #(.VAL_W(VW), .OUT_W(OW)) u_edge_delta_packer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_value_i  (in_value),
    .in_last_i   (in_last),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data),
    .out_last_o  (out_last),
    .err_o       (err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // model of R1/R2/R3/R5/R6: build expected words for one bucket
  task automatic add_bucket(input int vals[]);
    bit bq[$];
    int prev = 0;
    foreach (vals[k]) begin
      int g = (vals[k] - prev) & ((1 << VW) - 1);
      int l = 0;
      for (int b = 0; b < VW; b++) if ((g >> b) & 1) l = b + 1;
      for (int b = 0; b < l; b++) bq.push_back(1'b1);
      bq.push_back(1'b0);
      for (int b = 0; b < l; b++) bq.push_back(bit'((g >> b) & 1));
      prev = vals[k];
      in_vals.push_back(VW'(vals[k]));
      in_lasts.push_back(k == vals.size() - 1);
    end
    while (bq.size() % OW != 0) bq.push_back(1'b0);
    for (int w = 0; w < bq.size() / OW; w++) begin
      logic [OW-1:0] word = '0;
      for (int b = 0; b < OW; b++) word[b] = bq[w*OW + b];
      exp_words.push_back(word);
      exp_lasts.push_back(w == bq.size() / OW - 1);
    end
  endtask

  task automatic run_stream();
    int ii = 0;
    int cyc = 0;
    logic held = 1'b0;
    logic [OW-1:0] held_d = '0;
    logic held_l = 1'b0;
    while ((ii < in_vals.size() || exp_words.size() > 0) && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      in_valid  = (ii < in_vals.size()) && ($urandom % 4 != 0);
      in_value  = (ii < in_vals.size()) ? in_vals[ii] : '0;
      in_last   = (ii < in_vals.size()) ? in_lasts[ii] : 1'b0;
      out_ready = ($urandom % 3 != 0);
      #1;
      if (held) begin
        check("R4 valid held", 32'(out_valid), 32'd1);
        check("R4 data held", 32'(out_data), 32'(held_d));
        check("R4 last held", 32'(out_last), 32'(held_l));
      end
      held = out_valid && !out_ready;
      held_d = out_data;
      held_l = out_last;
      if (out_valid && out_ready) begin
        if (exp_words.size() == 0) begin
          check("R3 unexpected word", 32'(out_data), 32'hffff_ffff);
        end else begin
          check("R3 word", 32'(out_data), 32'(exp_words[0]));
          check("R5 last flag", 32'(out_last), 32'(exp_lasts[0]));
          void'(exp_words.pop_front());
          void'(exp_lasts.pop_front());
        end
      end
      if (in_valid && in_ready) ii++;
    end
    if (cyc >= 60000) check("R3 stream stalled", 32'd0, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_vals.delete();
    in_lasts.delete();
    #1;
    check("R5 no extra word", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 out_valid", 32'(out_valid), 32'd0);
    check("R9 err", 32'(err), 32'd0);
    check("R9 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // single-value bucket 255: code 0x1FEFF over 17 bits, two words
    @(negedge clk);
    in_valid = 1'b1; in_value = 8'hFF; in_last = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R7 ready low when full", 32'(in_ready), 32'd0);
    check("R2 first word", 32'(out_data), 32'h0000_FEFF);
    check("R5 first word not last", 32'(out_last), 32'd0);
    repeat (3) begin
      @(negedge clk); #1;
      check("R4 stall hold", 32'(out_data), 32'h0000_FEFF);
    end
    out_ready = 1'b1;
    @(negedge clk); #1;
    check("R5 padded tail", 32'(out_data), 32'h0000_0001);
    check("R5 tail last", 32'(out_last), 32'd1);
    check("R7 ready low on flush", 32'(in_ready), 32'd0);
    @(negedge clk); #1;
    out_ready = 1'b0;
    check("R6 drained", 32'(out_valid), 32'd0);
    check("R7 ready after flush", 32'(in_ready), 32'd1);

    // R1 R2 R6: every gap from zero and to the top, one bucket each
    for (int a = 0; a < 256; a++) add_bucket('{a, 255});
    // R3: long bucket with mixed gaps straddling word edges
    add_bucket('{0, 0, 1, 3, 7, 15, 31, 63, 127, 128, 130, 200, 255, 255});
    run_stream();
    check("R8 no error on sorted input", 32'(err), 32'd0);

    // R8: descent codes wrapped gap 226 and latches error
    add_bucket('{50, 20});
    add_bucket('{5, 9});
    run_stream();
    check("R8 error sticky", 32'(err), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule